// File: doc/BRIEF.md
# Parallel Bus Master

This block lets an on-chip host run single read and write cycles on an external parallel bus. Such a bus can carry memories, peripherals or another controller. The host sets a handful of configuration inputs: enable, master mode, data width, chip-select function, address multiplexing, address step mode and a per-pin address enable mask. It then pulses a start strobe with a direction, an address and write data. The block raises a busy flag and sequences the external strobes. On a read it returns the sampled data.

Each cycle has up to three phases: an optional address-latch phase, a strobe phase and a hold phase. In the partial-multiplex arrangement, the low address byte goes out on the low data lines during the latch phase, and a latch strobe marks it on address pin 0. The two most significant address pins can serve as chip selects instead of address lines. A pin used this way is left out of the automatic address stepping that runs after every cycle. The host can start a new cycle either at a fresh address or at the stepped address.

Top module: `parbus_master`

## Requirements
- R1: While cfgEnable is 0, or cfgMode is neither 2'b10 nor 2'b11, start is ignored: busy stays 0, no strobe or chip select asserts, and busAddrOe, busDataOe and busAddr are all zero.
- R2: With cfgMode = 2'b10, a read raises busRd and a write raises busWr. The raised strobe is high for exactly STROBE_CLKS clocks, and the two are never high together.
- R3: With cfgMode = 2'b11, busRd is a direction line that is high for the whole cycle of a read and low for a write. busWr is a common strobe that is high for STROBE_CLKS clocks in either direction.
- R4: With cfgWide = 0, only busDataOe[7:0] may assert, written data is driven as its low byte, and rdData[15:8] reads 0. With cfgWide = 1, all 16 data lines are used.
- R5: Chip-select function: 2'b00 and 2'b11 keep pins 15 and 14 as address. 2'b01 turns pin 15 into chip select 2. 2'b10 turns pin 15 into chip select 2 and pin 14 into chip select 1. A chip select pin is always enabled as an output. It is high only while a cycle is active and the matching stored address bit is 1, and it is 0 when idle.
- R6: When a cycle ends, cfgIncMode 2'b01 adds one to the stored address and 2'b10 subtracts one; 2'b00 and 2'b11 leave it alone. Bits in use as chip selects keep their value, and the step wraps within the remaining low bits.
- R7: With function 2'b10 and stored address bits 15 and 14 both 1, both chip selects assert during the cycle.
- R8: With cfgAddrMux = 2'b01, a latch phase of LATCH_CLKS clocks comes first. During it, busDataOut[7:0] carries the low address byte with busDataOe = 16'h00FF, and busAle, which also appears on busAddr[0], is high. Address pins 7..1 are not driven in this arrangement. Any other cfgAddrMux value skips the latch phase.
- R9: busy rises on the clock that accepts start. It stays high for LATCH_CLKS (multiplexed only) + STROBE_CLKS + HOLD_CLKS clocks. A start pulse while busy is ignored.
- R10: Outside chip-select and latch-strobe use, address pin i is driven, and busAddrOe[i] is 1, only if cfgPinEn[i] is 1. When idle, the pins show the stored address.
- R11: Read data is taken from busDataIn on the last clock of the strobe phase. Write data is driven from the first strobe clock to the end of the hold phase.
- R12: When startReuse is 1, the cycle uses the stored, already stepped address and ignores startAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEnable | input | 1 | Block enable |
| cfgMode | input | 2 | Master mode: 10 separate strobes, 11 direction plus strobe |
| cfgWide | input | 1 | 0 = 8-bit data, 1 = 16-bit data |
| cfgCsFunc | input | 2 | Chip-select function of pins 15 and 14 |
| cfgAddrMux | input | 2 | 01 = partial multiplex, others = separate address |
| cfgIncMode | input | 2 | 01 step up, 10 step down, others hold |
| cfgPinEn | input | 16 | Per-pin address output enable |
| startPulse | input | 1 | Start a cycle (one clock) |
| startWrite | input | 1 | 1 = write, 0 = read |
| startReuse | input | 1 | Use the stored address instead of startAddr |
| startAddr | input | 16 | Cycle address |
| wrData | input | 16 | Write data |
| busy | output | 1 | Cycle in progress |
| rdData | output | 16 | Last read data |
| busAddr | output | 16 | Address pins |
| busAddrOe | output | 16 | Address pin output enables |
| busDataOut | output | 16 | Data pins, driven value |
| busDataOe | output | 16 | Data pin output enables |
| busDataIn | input | 16 | Data pins, sampled value |
| busAle | output | 1 | Address latch strobe |
| busRd | output | 1 | Read strobe or direction line |
| busWr | output | 1 | Write strobe or common strobe |
| busCs1 | output | 1 | Chip select 1 |
| busCs2 | output | 1 | Chip select 2 |

## Verification
The bench builds the block with its default phase lengths: one latch clock, two strobe clocks and one hold clock. Two strobe clocks separate the first strobe clock from the last, so changing busDataIn between them shows which one the read sample is taken from. The short latch and hold phases keep every cycle at three or four clocks, so the exact busy length and strobe counts can be checked for each mode. The stepping, wrap and chip-select keep cases can be reached from chosen start addresses such as 16'hFFFF, 16'h0000 and 16'hC0FF.

// File: rtl/parbus_pkg.sv
package parbus_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int BYTE_W = DATA_W / 2;
  localparam int CS2_BIT = ADDR_W - 1;
  localparam int CS1_BIT = ADDR_W - 2;

  localparam logic [1:0] MODE_SPLIT  = 2'b10;
  localparam logic [1:0] MODE_DIRSTB = 2'b11;
  localparam logic [1:0] CSF_NONE    = 2'b00;
  localparam logic [1:0] CSF_HIGH    = 2'b01;
  localparam logic [1:0] CSF_BOTH    = 2'b10;
  localparam logic [1:0] MUX_PARTIAL = 2'b01;
  localparam logic [1:0] STEP_UP     = 2'b01;
  localparam logic [1:0] STEP_DOWN   = 2'b10;

  typedef enum logic [1:0] {PH_IDLE, PH_LATCH, PH_STROBE, PH_HOLD} phase_t;

  typedef struct packed {
    logic load;
    logic latchPh;
    logic strobePh;
    logic holdPh;
    logic capture;
    logic advance;
    logic active;
  } ctl_strobes_t;
endpackage

// File: rtl/parbus_ctrl.sv
module parbus_ctrl
  import parbus_pkg::*;
#(
  parameter int LATCH_CLKS  = 1,
  parameter int STROBE_CLKS = 2,
  parameter int HOLD_CLKS   = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         runOk,
  input  logic         muxOn,
  input  logic         startPulse,
  output ctl_strobes_t ctl,
  output logic         busy
);
  localparam int MAX_A    = (LATCH_CLKS > STROBE_CLKS) ? LATCH_CLKS : STROBE_CLKS;
  localparam int MAX_CLKS = (MAX_A > HOLD_CLKS) ? MAX_A : HOLD_CLKS;
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);
  localparam logic [CNT_W-1:0] LATCH_LAST  = CNT_W'(LATCH_CLKS - 1);
  localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CLKS - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CLKS - 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             lastCnt;

  always_comb begin
    case (phase)
      PH_LATCH:  lastCnt = (cnt == LATCH_LAST);
      PH_STROBE: lastCnt = (cnt == STROBE_LAST);
      PH_HOLD:   lastCnt = (cnt == HOLD_LAST);
      default:   lastCnt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (!runOk) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (startPulse) phase <= muxOn ? PH_LATCH : PH_STROBE;
        end
        PH_LATCH: begin
          if (lastCnt) begin
            phase <= PH_STROBE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_STROBE: begin
          if (lastCnt) begin
            phase <= PH_HOLD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (lastCnt) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    ctl.load     = (phase == PH_IDLE) && runOk && startPulse;
    ctl.latchPh  = (phase == PH_LATCH);
    ctl.strobePh = (phase == PH_STROBE);
    ctl.holdPh   = (phase == PH_HOLD);
    ctl.capture  = ctl.strobePh && lastCnt;
    ctl.advance  = ctl.holdPh && lastCnt;
    ctl.active   = (phase != PH_IDLE);
  end

  assign busy = ctl.active;

  AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ctl.strobePh) && runOk) |-> ($past(cnt) == STROBE_LAST)); // R9
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.strobePh && runOk && !lastCnt) |=> ctl.strobePh); // R9
endmodule

// File: rtl/parbus_dpath.sv
module parbus_dpath
  import parbus_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobes_t      ctl,
  input  logic              runOk,
  input  logic              muxOn,
  input  logic [1:0]        cfgMode,
  input  logic              cfgWide,
  input  logic [1:0]        cfgCsFunc,
  input  logic [1:0]        cfgIncMode,
  input  logic [ADDR_W-1:0] cfgPinEn,
  input  logic              startWrite,
  input  logic              startReuse,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [ADDR_W-1:0] busAddrOe,
  output logic [DATA_W-1:0] busDataOut,
  output logic [DATA_W-1:0] busDataOe,
  output logic              busAle,
  output logic              busRd,
  output logic              busWr,
  output logic              busCs1,
  output logic              busCs2
);
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic              isWrite;
  logic [ADDR_W-1:0] keepMask;
  logic [ADDR_W-1:0] stepVal;
  logic [ADDR_W-1:0] stepSum;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] pinVal;
  logic [ADDR_W-1:0] oeMask;
  logic [DATA_W-1:0] widthMask;
  logic              cs2On;
  logic              cs1On;

  assign cs2On = (cfgCsFunc == CSF_HIGH) || (cfgCsFunc == CSF_BOTH);
  assign cs1On = (cfgCsFunc == CSF_BOTH);
  assign widthMask = cfgWide ? {DATA_W{1'b1}} : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};

  // address stepping, chip-select bits held
  always_comb begin
    keepMask = '0;
    if (cs2On) keepMask[CS2_BIT] = 1'b1;
    if (cs1On) keepMask[CS1_BIT] = 1'b1;
    case (cfgIncMode)
      STEP_UP:   stepVal = ADDR_W'(1);
      STEP_DOWN: stepVal = {ADDR_W{1'b1}};
      default:   stepVal = '0;
    endcase
    stepSum  = (addrReg & ~keepMask) + stepVal;
    nextAddr = (addrReg & keepMask) | (stepSum & ~keepMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      isWrite <= 1'b0;
      rdData  <= '0;
    end else begin
      if (ctl.load) begin
        if (!startReuse) addrReg <= startAddr;
        dataReg <= wrData;
        isWrite <= startWrite;
      end
      if (ctl.capture && !isWrite) rdData <= busDataIn & widthMask;
      if (ctl.advance) addrReg <= nextAddr;
    end
  end

  assign busCs2 = runOk && cs2On && ctl.active && addrReg[CS2_BIT];
  assign busCs1 = runOk && cs1On && ctl.active && addrReg[CS1_BIT];
  assign busAle = runOk && muxOn && ctl.latchPh;

  always_comb begin
    pinVal = addrReg;
    oeMask = cfgPinEn;
    if (cs2On) begin
      pinVal[CS2_BIT] = busCs2;
      oeMask[CS2_BIT] = 1'b1;
    end
    if (cs1On) begin
      pinVal[CS1_BIT] = busCs1;
      oeMask[CS1_BIT] = 1'b1;
    end
    if (muxOn) begin
      pinVal[0]          = busAle;
      oeMask[BYTE_W-1:0] = BYTE_W'(1);
    end
    if (!runOk) oeMask = '0;
  end

  for (genvar i = 0; i < ADDR_W; i++) begin : g_pin
    assign busAddr[i]   = oeMask[i] & pinVal[i];
    assign busAddrOe[i] = oeMask[i];
  end

  always_comb begin
    busDataOut = '0;
    busDataOe  = '0;
    if (runOk && ctl.latchPh) begin
      busDataOut[BYTE_W-1:0] = addrReg[BYTE_W-1:0];
      busDataOe[BYTE_W-1:0]  = {BYTE_W{1'b1}};
    end else if (runOk && isWrite && (ctl.strobePh || ctl.holdPh)) begin
      busDataOut = dataReg & widthMask;
      busDataOe  = widthMask;
    end
  end

  always_comb begin
    busRd = 1'b0;
    busWr = 1'b0;
    if (runOk) begin
      if (cfgMode == MODE_SPLIT) begin
        busRd = ctl.strobePh && !isWrite;
        busWr = ctl.strobePh && isWrite;
      end else begin
        busRd = ctl.active && !isWrite;
        busWr = ctl.strobePh;
      end
    end
  end

  AST_SPLIT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == MODE_SPLIT) |-> !(busRd && busWr)); // R2
  AST_CS_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && cfgCsFunc == CSF_BOTH) |=> (addrReg[CS2_BIT:CS1_BIT] == $past(addrReg[CS2_BIT:CS1_BIT]))); // R6
  AST_ALE_MUX: assert property (@(posedge clk) disable iff (!rstN)
    busAle |-> (muxOn && busDataOe == DATA_W'({BYTE_W{1'b1}}))); // R8
  AST_PIN_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (busAddrOe[CS1_BIT-1:1] & ~cfgPinEn[CS1_BIT-1:1]) == '0); // R10
endmodule

// File: rtl/parbus_master.sv
module parbus_master
  import parbus_pkg::*;
#(
  parameter int LATCH_CLKS  = 1,
  parameter int STROBE_CLKS = 2,
  parameter int HOLD_CLKS   = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgEnable,
  input  logic [1:0]  cfgMode,
  input  logic        cfgWide,
  input  logic [1:0]  cfgCsFunc,
  input  logic [1:0]  cfgAddrMux,
  input  logic [1:0]  cfgIncMode,
  input  logic [15:0] cfgPinEn,
  input  logic        startPulse,
  input  logic        startWrite,
  input  logic        startReuse,
  input  logic [15:0] startAddr,
  input  logic [15:0] wrData,
  output logic        busy,
  output logic [15:0] rdData,
  output logic [15:0] busAddr,
  output logic [15:0] busAddrOe,
  output logic [15:0] busDataOut,
  output logic [15:0] busDataOe,
  input  logic [15:0] busDataIn,
  output logic        busAle,
  output logic        busRd,
  output logic        busWr,
  output logic        busCs1,
  output logic        busCs2
);
  ctl_strobes_t ctl;
  logic         runOk;
  logic         muxOn;

  assign runOk = cfgEnable && ((cfgMode == MODE_SPLIT) || (cfgMode == MODE_DIRSTB));
  assign muxOn = (cfgAddrMux == MUX_PARTIAL);

  parbus_ctrl #(
    .LATCH_CLKS (LATCH_CLKS),
    .STROBE_CLKS(STROBE_CLKS),
    .HOLD_CLKS  (HOLD_CLKS)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .runOk     (runOk),
    .muxOn     (muxOn),
    .startPulse(startPulse),
    .ctl       (ctl),
    .busy      (busy)
  );

  parbus_dpath dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .runOk     (runOk),
    .muxOn     (muxOn),
    .cfgMode   (cfgMode),
    .cfgWide   (cfgWide),
    .cfgCsFunc (cfgCsFunc),
    .cfgIncMode(cfgIncMode),
    .cfgPinEn  (cfgPinEn),
    .startWrite(startWrite),
    .startReuse(startReuse),
    .startAddr (startAddr),
    .wrData    (wrData),
    .busDataIn (busDataIn),
    .rdData    (rdData),
    .busAddr   (busAddr),
    .busAddrOe (busAddrOe),
    .busDataOut(busDataOut),
    .busDataOe (busDataOe),
    .busAle    (busAle),
    .busRd     (busRd),
    .busWr     (busWr),
    .busCs1    (busCs1),
    .busCs2    (busCs2)
  );

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> !busy); // R1
  AST_NARROW_HI: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWide |-> (busDataOe[15:8] == 8'h00)); // R4
  AST_CS1_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    busCs1 |-> (cfgCsFunc == CSF_BOTH && busy)); // R5
  AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busCs2 |-> busy); // R5
endmodule

// File: tb/parbus_master_tb.sv
module parbus_master_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgEnable = 1'b0;
  logic [1:0]  cfgMode = 2'b10;
  logic        cfgWide = 1'b0;
  logic [1:0]  cfgCsFunc = 2'b00;
  logic [1:0]  cfgAddrMux = 2'b00;
  logic [1:0]  cfgIncMode = 2'b00;
  logic [15:0] cfgPinEn = 16'hFFFF;
  logic        startPulse = 1'b0;
  logic        startWrite = 1'b0;
  logic        startReuse = 1'b0;
  logic [15:0] startAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] busDataIn = '0;
  logic        busy;
  logic [15:0] rdData, busAddr, busAddrOe, busDataOut, busDataOe;
  logic        busAle, busRd, busWr, busCs1, busCs2;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  parbus_master dut_i (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMode(cfgMode),
    .cfgWide(cfgWide), .cfgCsFunc(cfgCsFunc), .cfgAddrMux(cfgAddrMux),
    .cfgIncMode(cfgIncMode), .cfgPinEn(cfgPinEn), .startPulse(startPulse),
    .startWrite(startWrite), .startReuse(startReuse), .startAddr(startAddr),
    .wrData(wrData), .busy(busy), .rdData(rdData), .busAddr(busAddr),
    .busAddrOe(busAddrOe), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .busDataIn(busDataIn), .busAle(busAle), .busRd(busRd), .busWr(busWr),
    .busCs1(busCs1), .busCs2(busCs2)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        wide;
    logic [1:0]  csf;
    logic [1:0]  mux;
    logic [1:0]  inc;
    logic        wr;
    logic [15:0] addr;
    logic [15:0] data;
    logic [15:0] expRd;
    logic [15:0] expPins;
    logic [2:0]  expBusy;
    logic [2:0]  expRdN;
    logic [2:0]  expWrN;
    logic        expCs1;
    logic        expCs2;
    logic        expAle;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{2'b10, 1'b0, 2'b00, 2'b00, 2'b01, 1'b0, 16'h1234, 16'hABCD, 16'h00CD, 16'h1235, 3'd3, 3'd2, 3'd0, 1'b0, 1'b0, 1'b0},
    '{2'b10, 1'b1, 2'b00, 2'b00, 2'b10, 1'b1, 16'h0000, 16'hBEEF, 16'h0000, 16'hFFFF, 3'd3, 3'd0, 3'd2, 1'b0, 1'b0, 1'b0},
    '{2'b10, 1'b0, 2'b01, 2'b00, 2'b01, 1'b1, 16'hFFFF, 16'h5AA5, 16'h0000, 16'h0000, 3'd3, 3'd0, 3'd2, 1'b0, 1'b1, 1'b0},
    '{2'b11, 1'b1, 2'b10, 2'b00, 2'b01, 1'b0, 16'hC0FF, 16'h1357, 16'h1357, 16'h0100, 3'd3, 3'd3, 3'd2, 1'b1, 1'b1, 1'b0},
    '{2'b11, 1'b0, 2'b11, 2'b00, 2'b11, 1'b1, 16'hC001, 16'h1234, 16'h0000, 16'hC001, 3'd3, 3'd0, 3'd2, 1'b0, 1'b0, 1'b0},
    '{2'b10, 1'b0, 2'b00, 2'b01, 2'b01, 1'b0, 16'h3456, 16'h00EE, 16'h00EE, 16'h3400, 3'd4, 3'd2, 3'd0, 1'b0, 1'b0, 1'b1},
    '{2'b10, 1'b1, 2'b10, 2'b00, 2'b10, 1'b0, 16'h4000, 16'hFFFF, 16'hFFFF, 16'h3FFF, 3'd3, 3'd2, 3'd0, 1'b1, 1'b0, 1'b0},
    '{2'b10, 1'b1, 2'b01, 2'b00, 2'b01, 1'b1, 16'h8000, 16'h0F0F, 16'h0000, 16'h0001, 3'd3, 3'd0, 3'd2, 1'b0, 1'b1, 1'b0}
  };

  int          nBusy, nRd, nWr, nAle;
  logic        sawCs1, sawCs2;
  logic [15:0] wrSeen, wrOeSeen, aleData;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOne(input logic wr, input logic reuse, input logic [15:0] addr,
                        input logic [15:0] data);
    @(negedge clk);
    startPulse = 1'b1;
    startWrite = wr;
    startReuse = reuse;
    startAddr  = addr;
    wrData     = data;
    busDataIn  = data;
    @(negedge clk);
    startPulse = 1'b0;
    nBusy = 0; nRd = 0; nWr = 0; nAle = 0;
    sawCs1 = 1'b0; sawCs2 = 1'b0;
    wrSeen = '0; wrOeSeen = '0; aleData = '0;
    while (busy && nBusy < 40) begin
      nBusy++;
      if (busRd) nRd++;
      if (busWr) begin
        nWr++;
        wrSeen   = busDataOut;
        wrOeSeen = wrOeSeen | busDataOe;
      end
      if (busAle) begin
        nAle++;
        aleData = busDataOut & busDataOe;
      end
      sawCs1 = sawCs1 | busCs1;
      sawCs2 = sawCs2 | busCs2;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk("R1 reset busy", {31'd0, busy}, 32'd0);
    chk("R1 reset rdData", {16'd0, rdData}, 32'd0);
    chk("R1 reset addr oe", {16'd0, busAddrOe}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // disabled: start ignored
    runOne(1'b1, 1'b0, 16'h00AA, 16'h1111);
    chk("R1 disabled busy", nBusy, 0);
    chk("R1 disabled strobes", {16'd0, busAddr | busDataOe}, 32'd0);
    cfgEnable = 1'b1;
    cfgMode   = 2'b00;
    runOne(1'b0, 1'b0, 16'h00AA, 16'h1111);
    chk("R1 bad mode busy", nBusy, 0);
    chk("R1 bad mode pins", {16'd0, busAddrOe}, 32'd0);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      string t;
      @(negedge clk);
      cfgMode    = VECS[v].mode;
      cfgWide    = VECS[v].wide;
      cfgCsFunc  = VECS[v].csf;
      cfgAddrMux = VECS[v].mux;
      cfgIncMode = VECS[v].inc;
      runOne(VECS[v].wr, 1'b0, VECS[v].addr, VECS[v].data);
      t = (VECS[v].mode == 2'b11) ? "R3" : "R2";
      chk($sformatf("R9 busy length v%0d", v), nBusy, {29'd0, VECS[v].expBusy});
      chk($sformatf("%s read strobe count v%0d", t, v), nRd, {29'd0, VECS[v].expRdN});
      chk($sformatf("%s write strobe count v%0d", t, v), nWr, {29'd0, VECS[v].expWrN});
      chk($sformatf("R5 cs1 v%0d", v), {31'd0, sawCs1}, {31'd0, VECS[v].expCs1});
      chk($sformatf("R5 cs2 v%0d", v), {31'd0, sawCs2}, {31'd0, VECS[v].expCs2});
      chk($sformatf("R6 stepped pins v%0d", v), {16'd0, busAddr}, {16'd0, VECS[v].expPins});
      chk($sformatf("R8 latch count v%0d", v), nAle, {31'd0, VECS[v].expAle});
      if (VECS[v].expAle)
        chk($sformatf("R8 latch byte v%0d", v), {16'd0, aleData}, {24'd0, VECS[v].addr[7:0]});
      if (VECS[v].wr) begin
        chk($sformatf("R4 write data v%0d", v), {16'd0, wrSeen},
            {16'd0, VECS[v].wide ? VECS[v].data : {8'h00, VECS[v].data[7:0]}});
        chk($sformatf("R4 write oe v%0d", v), {16'd0, wrOeSeen},
            {16'd0, VECS[v].wide ? 16'hFFFF : 16'h00FF});
      end else begin
        chk($sformatf("R4 read data v%0d", v), {16'd0, rdData}, {16'd0, VECS[v].expRd});
      end
    end

    // both chip selects at 11 in the top bits
    cfgMode = 2'b10; cfgWide = 1'b1; cfgCsFunc = 2'b10; cfgAddrMux = 2'b00; cfgIncMode = 2'b00;
    runOne(1'b0, 1'b0, 16'hFFFF, 16'h0000);
    chk("R7 both cs", {30'd0, sawCs2, sawCs1}, 32'd3);

    // kept chip-select bit observed through a reuse cycle
    cfgCsFunc = 2'b01; cfgIncMode = 2'b01;
    runOne(1'b1, 1'b0, 16'hFFFF, 16'h0000);
    runOne(1'b0, 1'b1, 16'h0000, 16'h0000);
    chk("R6 kept cs bit", {31'd0, sawCs2}, 32'd1);
    chk("R12 reuse stepped addr", {16'd0, busAddr}, 32'h0000_0001);

    // start during busy is ignored
    cfgCsFunc = 2'b00;
    @(negedge clk);
    startPulse = 1'b1; startWrite = 1'b0; startReuse = 1'b0; startAddr = 16'h0100;
    @(negedge clk);
    startPulse = 1'b0;
    @(negedge clk);
    startPulse = 1'b1; startAddr = 16'h7777;
    @(negedge clk);
    startPulse = 1'b0;
    while (busy) @(negedge clk);
    chk("R9 start while busy ignored", {16'd0, busAddr}, 32'h0000_0101);

    // read sample point
    cfgIncMode = 2'b00;
    @(negedge clk);
    startPulse = 1'b1; startWrite = 1'b0; startAddr = 16'h0010;
    @(negedge clk);
    startPulse = 1'b0; busDataIn = 16'h1111;
    @(negedge clk);
    busDataIn = 16'h2222;
    @(negedge clk);
    busDataIn = 16'h3333;
    @(negedge clk);
    chk("R11 last strobe sample", {16'd0, rdData}, 32'h0000_2222);

    // pin enable mask
    cfgPinEn = 16'h00F0;
    runOne(1'b0, 1'b0, 16'h0FF0, 16'h0000);
    chk("R10 pin oe", {16'd0, busAddrOe}, 32'h0000_00F0);
    chk("R10 pin value", {16'd0, busAddr}, 32'h0000_00F0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule